// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block holds the digital side of an 8-bit successive-approximation analog-to-digital converter. It chooses which of eight analog inputs the front end looks at and drives the trial code into the DAC. It reads one comparator bit per cycle and builds each result from the most significant bit down. The comparator, the DAC and the sample-and-hold stay outside the block.

There are two ways to start a run. A single-channel run converts one chosen input out of the eight. A group run converts the four inputs of the lower group (0 to 3) or of the upper group (4 to 7), one after another. Each channel conversion begins with a programmable sampling window, during which the channel select does not change. The window is followed by eight bit trials. Results land in four result slots that a read port exposes. When the run ends, the block gives a one-cycle interrupt pulse and sets a sticky completion flag.

Top module: `sar_adc_seq`

## Requirements
- R1: A conversion makes eight bit trials, most significant bit first, one per clock. During the trial for bit b, `dac_code` equals the bits already kept above b with bit b set and all lower bits clear. Bit b is kept when `cmp_in` is 1 in that cycle.
- R2: The comparator is read as "input at or above the DAC level". When the input equals a trial level the bit is kept, so the stored result equals the input's ideal code (for example 0x80 gives 0x80, 0x00 gives 0x00, 0xFF gives 0xFF).
- R3: Every channel conversion starts with max(`samp_cycles`,1) sampling cycles. In these cycles `sample_en` is 1, `dac_code` is 0 and `chan_sel` holds the channel being converted. The first sampling cycle is the one after the clock edge that accepts `start`.
- R4: With `scan_mode`=0, a start converts only channel `sel_chan` and writes the result to slot `sel_chan[1:0]`.
- R5: With `scan_mode`=1, a start converts channels base+0 to base+3 in ascending order, where base is 4 if `scan_upper`=1 and 0 otherwise. The result for group position k goes to slot k. The next channel's sampling starts in the cycle right after the previous channel's last trial.
- R6: `done_irq` is high for exactly one cycle, the cycle after the final trial of a run. `done_flag` rises in that same cycle and stays high until the next accepted start clears it.
- R7: A `start` that arrives while `busy` is 1 is ignored. The run in progress, its channels and the slot contents it produces do not change.
- R8: While `rst_n` is low, `busy`, `sample_en`, `done_irq` and `done_flag` are 0, `dac_code` is 0, `chan_sel` is 0 and every result slot reads 0.
- R9: `busy` is 1 from the cycle after an accepted start through the last trial cycle of the run, and 0 otherwise.
- R10: `rd_data` shows the slot chosen by `rd_idx` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only when idle |
| scan_mode | input | 1 | 1: group run, 0: single-channel run |
| scan_upper | input | 1 | Group choice for a group run: 1 selects channels 4-7 |
| sel_chan | input | 3 | Channel for a single-channel run |
| samp_cycles | input | 4 | Sampling window length (0 acts as 1) |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code | output | 8 | Trial code to the DAC, 0 outside trials |
| chan_sel | output | 3 | Analog channel select |
| sample_en | output | 1 | Sample-and-hold tracking window |
| busy | output | 1 | Run in progress |
| done_irq | output | 1 | One-cycle end-of-run interrupt |
| done_flag | output | 1 | Sticky end-of-run flag |
| rd_idx | input | 2 | Result slot to read |
| rd_data | output | 8 | Contents of the selected slot |

## Verification
A wrong bit mask or a wrong kept-bit register shows on `dac_code` in the very next trial cycle, because every later trial level contains the earlier decisions. A channel counter or group position that is off shows on `chan_sel` during the next sampling window, and later shows as a wrong slot through `rd_data`. A sampling counter that is off by one moves the first nonzero `dac_code` and the rise of `done_irq` by a cycle. For these reasons the reference model is compared against every output on every clock, not only at the final results.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_TRIAL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_bit_search.sv
module sar_bit_search #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             trial,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] code_next,
  output logic             last_bit
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc_q, acc_d;
  logic [RES_W-1:0] mask_q, mask_d;

  always_comb begin
    code_next = cmp_in ? (acc_q | mask_q) : acc_q;
    dac_code  = trial ? (acc_q | mask_q) : '0;
    last_bit  = mask_q[0];
    acc_d     = acc_q;
    mask_d    = mask_q;
    if (clear) begin
      acc_d  = '0;
      mask_d = TOP_BIT;
    end else if (trial) begin
      acc_d  = code_next;
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mask_q <= TOP_BIT;
    end else begin
      acc_q  <= acc_d;
      mask_q <= mask_d;
    end
  end

  // R1: at most one trial bit is live at a time
  a_r1_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
  // R1: a high comparator keeps the bit under trial
  a_r1_keep_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    (trial && cmp_in) |=> ((acc_q & $past(mask_q)) != '0));
  // R1: a low comparator drops the bit under trial
  a_r1_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (trial && !cmp_in) |=> ((acc_q & $past(mask_q)) == '0));
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int RES_W = 8,
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RES_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data
);
  logic [DEPTH-1:0][RES_W-1:0] slot_data;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [RES_W-1:0] val_q;
    logic             load;
    assign load = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (load) val_q <= wr_data;
    end
    assign slot_data[g] = val_q;
  end

  assign rd_data = slot_data[rd_idx];

  // R10: a slot written with the read index on it shows the new value next cycle
  a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx) |=> (($past(rd_idx) != rd_idx) || (rd_data == $past(wr_data))));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int GRP    = 4,
  parameter int SAMP_W = 4,
  localparam int POS_W = $clog2(GRP),
  localparam int CH_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              scan_mode,
  input  logic              scan_upper,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [SAMP_W-1:0] samp_cycles,
  input  logic              trial_last,
  output logic              clear,
  output logic              trial,
  output logic              sample_en,
  output logic              busy,
  output logic [CH_W-1:0]   chan_sel,
  output logic              wr_en,
  output logic [POS_W-1:0]  wr_idx,
  output logic              done_irq,
  output logic              done_flag
);
  seq_state_e        st_q, st_d;
  logic [SAMP_W-1:0] cnt_q, cnt_d, len_q, len_d, len_eff;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              single_q, single_d;
  logic              irq_q, irq_d, flag_q, flag_d;
  logic              accept, conv_end, run_end;

  always_comb begin
    accept    = (st_q == SEQ_IDLE) && start;
    trial     = (st_q == SEQ_TRIAL);
    sample_en = (st_q == SEQ_SAMPLE);
    clear     = sample_en;
    busy      = (st_q != SEQ_IDLE);
    conv_end  = trial && trial_last;
    run_end   = conv_end && (single_q || (pos_q == POS_W'(GRP - 1)));
    wr_en     = conv_end;
    wr_idx    = pos_q;
    len_eff   = (samp_cycles == '0) ? SAMP_W'(1) : samp_cycles;
  end

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    pos_d    = pos_q;
    chan_d   = chan_q;
    single_d = single_q;
    flag_d   = flag_q;
    irq_d    = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d   = SEQ_SAMPLE;
          len_d  = len_eff;
          cnt_d  = len_eff;
          flag_d = 1'b0;
          if (scan_mode) begin
            single_d = 1'b0;
            pos_d    = '0;
            chan_d   = scan_upper ? CH_W'(GRP) : '0;
          end else begin
            single_d = 1'b1;
            pos_d    = sel_chan[POS_W-1:0];
            chan_d   = sel_chan;
          end
        end
      end
      SEQ_SAMPLE: begin
        cnt_d = cnt_q - SAMP_W'(1);
        if (cnt_q == SAMP_W'(1)) st_d = SEQ_TRIAL;
      end
      SEQ_TRIAL: begin
        if (trial_last) begin
          if (run_end) begin
            st_d   = SEQ_IDLE;
            irq_d  = 1'b1;
            flag_d = 1'b1;
          end else begin
            st_d   = SEQ_SAMPLE;
            pos_d  = pos_q + POS_W'(1);
            chan_d = chan_q + CH_W'(1);
            cnt_d  = len_q;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      pos_q    <= '0;
      chan_q   <= '0;
      single_q <= 1'b0;
      irq_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      pos_q    <= pos_d;
      chan_q   <= chan_d;
      single_q <= single_d;
      irq_q    <= irq_d;
      flag_q   <= flag_d;
    end
  end

  assign chan_sel  = chan_q;
  assign done_irq  = irq_q;
  assign done_flag = flag_q;

  // R9: an accepted start makes the block busy on the next cycle
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R3: every run opens with a sampling window
  a_r3_sample_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sample_en);
  // R3: the channel select holds still across the sampling window
  a_r3_chan_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && $past(sample_en)) |-> $stable(chan_sel));
  // R7: a start during a run leaves the run's set-up untouched
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !run_end) |=> ($stable(single_q) && $stable(len_q)));
  // R6: the interrupt lasts one cycle
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R6: the interrupt comes with the flag, and only when idle
  a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (done_flag && !busy));
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W  = 8,
  parameter int GRP    = 4,
  parameter int SAMP_W = 4,
  localparam int POS_W = $clog2(GRP),
  localparam int CH_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              scan_mode,
  input  logic              scan_upper,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [SAMP_W-1:0] samp_cycles,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic [CH_W-1:0]   chan_sel,
  output logic              sample_en,
  output logic              busy,
  output logic              done_irq,
  output logic              done_flag,
  input  logic [POS_W-1:0]  rd_idx,
  output logic [RES_W-1:0]  rd_data
);
  logic             clear, trial, trial_last, wr_en;
  logic [POS_W-1:0] wr_idx;
  logic [RES_W-1:0] code_next;

  sar_ctrl #(.GRP(GRP), .SAMP_W(SAMP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_mode(scan_mode),
    .scan_upper(scan_upper), .sel_chan(sel_chan), .samp_cycles(samp_cycles),
    .trial_last(trial_last), .clear(clear), .trial(trial), .sample_en(sample_en),
    .busy(busy), .chan_sel(chan_sel), .wr_en(wr_en), .wr_idx(wr_idx),
    .done_irq(done_irq), .done_flag(done_flag)
  );

  sar_bit_search #(.RES_W(RES_W)) u_search (
    .clk(clk), .rst_n(rst_n), .clear(clear), .trial(trial), .cmp_in(cmp_in),
    .dac_code(dac_code), .code_next(code_next), .last_bit(trial_last)
  );

  sar_result_bank #(.RES_W(RES_W), .DEPTH(GRP)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(code_next),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_sar_adc_seq.sv
module tb_sar_adc_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, scan_mode, scan_upper;
  logic [2:0] sel_chan;
  logic [3:0] samp_cycles;
  logic       cmp_in;
  logic [7:0] dac_code;
  logic [2:0] chan_sel;
  logic       sample_en, busy, done_irq, done_flag;
  logic [1:0] rd_idx;
  logic [7:0] rd_data;
  logic [7:0] vin [8];

  int checks = 0;
  int errors = 0;
  bit checking = 0;
  bit cur_busy = 0;
  bit model_flag = 0;
  int model_res [4];

  typedef struct {
    bit busy;
    bit samp;
    int chan;
    int dac;
    bit irq;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  assign cmp_in = (vin[chan_sel] >= dac_code);

  sar_adc_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_mode(scan_mode),
    .scan_upper(scan_upper), .sel_chan(sel_chan), .samp_cycles(samp_cycles),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
    .sample_en(sample_en), .busy(busy), .done_irq(done_irq),
    .done_flag(done_flag), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic void plan_run(bit scan, bit upper, int sel, int n);
    int nn = (n == 0) ? 1 : n;
    int first = scan ? (upper ? 4 : 0) : sel;
    int cnt = scan ? 4 : 1;
    for (int k = 0; k < cnt; k++) begin
      int ch = first + k;
      int slot = scan ? k : (sel % 4);
      int v = vin[ch];
      for (int s = 0; s < nn; s++) q.push_back('{1, 1, ch, 0, 0});
      for (int b = 7; b >= 0; b--) begin
        int lvl = (v & ~((1 << (b + 1)) - 1)) | (1 << b);
        q.push_back('{1, 0, ch, lvl, 0});
      end
      model_res[slot] = v;
    end
    q.push_back('{0, 0, -1, 0, 1});
  endfunction

  // reference model: accepts a start only when idle (R7)
  always @(posedge clk) begin
    if (rst_n && checking && start && !cur_busy) begin
      plan_run(scan_mode, scan_upper, int'(sel_chan), int'(samp_cycles));
      model_flag = 0;
    end
  end

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && checking) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{0, 0, -1, 0, 0};
      cur_busy = e.busy;
      if (e.irq) model_flag = 1;
      chk(busy == e.busy, "R9 busy", int'(busy), int'(e.busy));
      chk(sample_en == e.samp, "R3 sample_en", int'(sample_en), int'(e.samp));
      if (e.chan >= 0) chk(int'(chan_sel) == e.chan, "R5 chan_sel", int'(chan_sel), e.chan);
      chk(int'(dac_code) == e.dac, "R1 dac_code", int'(dac_code), e.dac);
      chk(done_irq == e.irq, "R6 done_irq", int'(done_irq), int'(e.irq));
      chk(done_flag == model_flag, "R6 done_flag", int'(done_flag), int'(model_flag));
      if (!e.busy)
        chk(int'(rd_data) == model_res[rd_idx], "R10 rd_data", int'(rd_data), model_res[rd_idx]);
    end
  end

  task automatic go(input bit scan, input bit upper, input int sel, input int n);
    @(posedge clk); #2;
    scan_mode = scan; scan_upper = upper; sel_chan = 3'(sel); samp_cycles = 4'(n);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_slot(input int idx, input int exp, input string tag);
    @(posedge clk); #2;
    rd_idx = 2'(idx);
    @(negedge clk);
    chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model_res[i] = 0;
    vin[0] = 8'h00; vin[1] = 8'hFF; vin[2] = 8'h55; vin[3] = 8'h3C;
    vin[4] = 8'hC3; vin[5] = 8'hA7; vin[6] = 8'h80; vin[7] = 8'h01;
    rst_n = 1'b0; start = 1'b0; scan_mode = 1'b0; scan_upper = 1'b0;
    sel_chan = '0; samp_cycles = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R8: state while held in reset
    chk(busy == 1'b0, "R8 busy", int'(busy), 0);
    chk(dac_code == 8'h00, "R8 dac_code", int'(dac_code), 0);
    chk(chan_sel == 3'd0, "R8 chan_sel", int'(chan_sel), 0);
    chk(done_flag == 1'b0 && done_irq == 1'b0, "R8 done", int'(done_flag), 0);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1 chk(rd_data == 8'h00, "R8 slot", int'(rd_data), 0);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    checking = 1;
    repeat (2) @(negedge clk);

    // R4: single channel 5, three sampling cycles, lands in slot 1
    go(0, 0, 5, 3); wait_idle();
    read_slot(1, 8'hA7, "R4 slot of channel 5");

    // R2: exact mid-scale input with a zero window (acts as one cycle)
    vin[2] = 8'h80;
    go(0, 0, 2, 0); wait_idle();
    read_slot(2, 8'h80, "R2 equal level kept");

    // R5: lower group, extremes 0x00 and 0xFF included
    vin[2] = 8'h55;
    go(1, 0, 0, 2); wait_idle();
    read_slot(0, 8'h00, "R5 lower slot0");
    read_slot(1, 8'hFF, "R5 lower slot1");
    read_slot(2, 8'h55, "R5 lower slot2");
    read_slot(3, 8'h3C, "R5 lower slot3");
    // R6: flag stays up while idle
    repeat (5) @(negedge clk);
    chk(done_flag == 1'b1, "R6 flag held", int'(done_flag), 1);

    // R7: upper group with a conflicting start mid-run
    go(1, 1, 0, 5);
    repeat (10) @(posedge clk);
    #2; scan_mode = 1'b0; sel_chan = 3'd0; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    wait_idle();
    read_slot(0, 8'hC3, "R7 slot0 keeps channel 4 result");
    read_slot(3, 8'h01, "R5 upper slot3");

    // R4: single channel 7 overwrites slot 3 with a new value
    vin[7] = 8'h7E;
    go(0, 0, 7, 15); wait_idle();
    read_slot(3, 8'h7E, "R4 slot of channel 7");
    read_slot(0, 8'hC3, "R4 other slot untouched");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule